// File: doc/BRIEF.md
# Pulse-Width Infrared Command Decoder

This block recovers a fixed-length command word from a demodulated infrared receiver line. The line is active low and rests high. Information is carried only in the duration of each low interval, called a mark. A long mark opens a frame. Each data mark that follows is read as a zero when short and as a one when about twice as long. Data marks are separated by high spaces of fixed length. The block measures every mark in clock cycles after the line has been brought into the clock domain. It classifies each mark at the moment the line returns high, and it assembles the bits with the first bit received placed in the least significant position.

When the last bit of a frame arrives, the whole word is copied to the parallel output in a single cycle, and a strobe is raised for exactly that cycle. The output holds its value until the next complete frame. The decoder drops a frame in progress and goes back to hunting for a start mark in three cases: a mark whose length fits no window, a space that lasts too long, or a new start mark, which begins a fresh frame at once. All thresholds are parameters in clock cycles. The defaults suit a 50 MHz clock, with a 2.4 ms start mark, 0.6 ms and 1.2 ms data marks and 0.6 ms spaces.

The strobe has no ready input and cannot be held off. A consumer that needs the word must capture it in the strobe cycle or read the held output afterwards. The output word stays stable until the next strobe.

Top module: `ir_pulse_decoder`

## Requirements
- R1: After a synchronous active-high reset, `frame_o` is all zeros, `frame_valid_o` is low, and the decoder is waiting for a start mark.
- R2: While waiting, a mark lasting START_MIN to START_MAX cycles inclusive opens a frame. Any mark length outside that window is ignored and produces no strobe.
- R3: Inside a frame, a data mark of ZERO_MIN to ZERO_MAX cycles inclusive is a 0, and one of ZERO_MAX+1 to ONE_MAX cycles inclusive is a 1.
- R4: The first data bit of a frame lands in `frame_o` bit 0, and the bit received k-th lands in bit k-1.
- R5: When the NBITS-th data mark ends, `frame_o` takes the complete word and `frame_valid_o` is high for exactly one cycle, and only when a frame was in progress.
- R6: `frame_o` changes only in a cycle where `frame_valid_o` is high. Aborted or partial frames leave it unchanged.
- R7: A data mark fitting neither the zero window nor the one window aborts the frame, and the bits that follow are ignored until a new start. A start-length mark inside a frame discards the partial word and opens a new frame.
- R8: Inside a frame, a high space lasting more than SPACE_TIMEOUT cycles aborts the frame. A space of exactly SPACE_TIMEOUT cycles does not.
- R9: The mark-length counter saturates at its all-ones value. A mark longer than the counter range is rejected and never wraps to a length inside a valid window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all thresholds are counted in its cycles |
| rst | input | 1 | Synchronous active-high reset |
| ir_line_n | input | 1 | Raw demodulated receiver line, low during a mark, asynchronous to `clk` |
| frame_o | output | NBITS | Last complete command word, first received bit in bit 0 |
| frame_valid_o | output | 1 | One-cycle strobe in the cycle `frame_o` takes a new word |

## Verification
The cases hardest to reach from the pins are the counter limits. One is a mark long enough to saturate the length counter: if the counter wrapped, the remainder would alias to a start. The other is a space that ends exactly at, or one cycle past, the timeout. The bench builds the decoder with small cycle thresholds and a 6-bit counter. It holds the line low for 112 cycles, which is 48 cycles past a wrap and therefore a valid start if the counter wrapped, and then sends twelve well-formed data marks that must not produce a strobe. It also sweeps every start length, every data mark length at one bit position, and every space length around the timeout. For each, the expected word or the absence of a strobe is computed from the windows.

// File: rtl/ir_dec_pkg.sv
package ir_dec_pkg;

  typedef enum logic [1:0] {
    MK_BAD   = 2'd0,
    MK_START = 2'd1,
    MK_ZERO  = 2'd2,
    MK_ONE   = 2'd3
  } mark_kind_t;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_BITS = 1'b1
  } dec_state_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/ir_line_sync.sv
module ir_line_sync (
  input  logic clk,
  input  logic rst,
  input  logic line_raw,
  output logic line_s,
  output logic rise
);
  logic meta_q;
  logic sync_q;
  logic last_q;

  // Two flops into the clock domain plus one for edge detection; idle is high.
  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      last_q <= 1'b1;
    end else begin
      meta_q <= line_raw;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign line_s = sync_q;
  assign rise   = sync_q & ~last_q;
endmodule

// File: rtl/ir_sat_counter.sv
module ir_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  // Counts cycles while run is high, holds at TOP, clears when run drops.
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      count <= '0;
    end else if (count != TOP) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/ir_mark_class.sv
module ir_mark_class
  import ir_dec_pkg::*;
#(
  parameter int W         = 18,
  parameter int START_MIN = 90000,
  parameter int START_MAX = 150000,
  parameter int ZERO_MIN  = 20000,
  parameter int ZERO_MAX  = 45000,
  parameter int ONE_MAX   = 80000
) (
  input  logic [W-1:0] len,
  output mark_kind_t   kind
);
  localparam logic [W-1:0] S_LO = W'(START_MIN);
  localparam logic [W-1:0] S_HI = W'(START_MAX);
  localparam logic [W-1:0] Z_LO = W'(ZERO_MIN);
  localparam logic [W-1:0] Z_HI = W'(ZERO_MAX);
  localparam logic [W-1:0] O_HI = W'(ONE_MAX);

  always_comb begin
    kind = MK_BAD;
    if (len >= S_LO && len <= S_HI)      kind = MK_START;
    else if (len >= Z_LO && len <= Z_HI) kind = MK_ZERO;
    else if (len > Z_HI && len <= O_HI)  kind = MK_ONE;
  end
endmodule

// File: rtl/ir_frame_asm.sv
module ir_frame_asm
  import ir_dec_pkg::*;
#(
  parameter int NBITS = 12,
  parameter int BCW   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  input  mark_kind_t       kind,
  input  logic             space_over,
  output logic [NBITS-1:0] frame_o,
  output logic             frame_valid_o,
  output dec_state_t       state_o,
  output logic [BCW-1:0]   bitcnt_o
);
  localparam logic [BCW-1:0] LAST = BCW'(NBITS - 1);

  dec_state_t       state_q;
  logic [BCW-1:0]   bitcnt_q;
  logic [NBITS-1:0] shreg_q;
  logic [NBITS-1:0] word_next;
  logic             data_bit;
  logic             is_data;

  assign data_bit = (kind == MK_ONE);
  assign is_data  = (kind == MK_ONE) || (kind == MK_ZERO);

  // Insert the incoming bit at the position given by the bit counter.
  for (genvar i = 0; i < NBITS; i++) begin : g_ins
    assign word_next[i] = (bitcnt_q == BCW'(i)) ? data_bit : shreg_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_HUNT;
      bitcnt_q      <= '0;
      shreg_q       <= '0;
      frame_o       <= '0;
      frame_valid_o <= 1'b0;
    end else begin
      frame_valid_o <= 1'b0;
      if (rise) begin
        if (kind == MK_START) begin
          state_q  <= ST_BITS;
          bitcnt_q <= '0;
          shreg_q  <= '0;
        end else if (state_q == ST_BITS) begin
          if (is_data) begin
            shreg_q <= word_next;
            if (bitcnt_q == LAST) begin
              frame_o       <= word_next;
              frame_valid_o <= 1'b1;
              state_q       <= ST_HUNT;
              bitcnt_q      <= '0;
            end else begin
              bitcnt_q <= bitcnt_q + 1'b1;
            end
          end else begin
            state_q  <= ST_HUNT;
            bitcnt_q <= '0;
          end
        end
      end else if (state_q == ST_BITS && space_over) begin
        state_q  <= ST_HUNT;
        bitcnt_q <= '0;
      end
    end
  end

  assign state_o  = state_q;
  assign bitcnt_o = bitcnt_q;
endmodule

// File: rtl/ir_pulse_decoder.sv
module ir_pulse_decoder
  import ir_dec_pkg::*;
#(
  parameter int NBITS         = 12,
  parameter int START_MIN     = 90000,
  parameter int START_MAX     = 150000,
  parameter int ZERO_MIN      = 20000,
  parameter int ZERO_MAX      = 45000,
  parameter int ONE_MAX       = 80000,
  parameter int SPACE_TIMEOUT = 150000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ir_line_n,
  output logic [NBITS-1:0] frame_o,
  output logic             frame_valid_o
);
  localparam int LIM = max3(START_MAX, ONE_MAX, SPACE_TIMEOUT);
  localparam int W   = $clog2(LIM + 2);
  localparam int BCW = $clog2(NBITS);

  logic           line_s;
  logic           rise;
  logic [W-1:0]   low_len;
  logic [W-1:0]   high_len;
  logic           space_over;
  mark_kind_t     kind;
  dec_state_t     state;
  logic [BCW-1:0] bitcnt;

  ir_line_sync i_sync (
    .clk      (clk),
    .rst      (rst),
    .line_raw (ir_line_n),
    .line_s   (line_s),
    .rise     (rise)
  );

  ir_sat_counter #(.W(W)) i_mark_cnt (
    .clk   (clk),
    .rst   (rst),
    .run   (~line_s),
    .count (low_len)
  );

  ir_sat_counter #(.W(W)) i_space_cnt (
    .clk   (clk),
    .rst   (rst),
    .run   (line_s),
    .count (high_len)
  );

  ir_mark_class #(
    .W         (W),
    .START_MIN (START_MIN),
    .START_MAX (START_MAX),
    .ZERO_MIN  (ZERO_MIN),
    .ZERO_MAX  (ZERO_MAX),
    .ONE_MAX   (ONE_MAX)
  ) i_class (
    .len  (low_len),
    .kind (kind)
  );

  assign space_over = line_s && (high_len >= W'(SPACE_TIMEOUT));

  ir_frame_asm #(.NBITS(NBITS), .BCW(BCW)) i_asm (
    .clk           (clk),
    .rst           (rst),
    .rise          (rise),
    .kind          (kind),
    .space_over    (space_over),
    .frame_o       (frame_o),
    .frame_valid_o (frame_valid_o),
    .state_o       (state),
    .bitcnt_o      (bitcnt)
  );
endmodule

// File: rtl/ir_pulse_decoder_chk.sv
module ir_pulse_decoder_chk
  import ir_dec_pkg::*;
#(
  parameter int NBITS         = 12,
  parameter int W             = 18,
  parameter int BCW           = 4,
  parameter int SPACE_TIMEOUT = 150000
) (
  input logic             clk,
  input logic             rst,
  input logic             line_s,
  input logic [W-1:0]     low_len,
  input logic [W-1:0]     high_len,
  input dec_state_t       state,
  input logic [BCW-1:0]   bitcnt,
  input logic [NBITS-1:0] frame_o,
  input logic             frame_valid_o
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!frame_valid_o && frame_o == '0 && state == ST_HUNT));

  assert_bit_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    bitcnt <= BCW'(NBITS - 1));

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst)
    frame_valid_o |=> !frame_valid_o);

  assert_strobe_from_frame_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_valid_o) |-> $past(state) == ST_BITS);

  assert_frame_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !frame_valid_o |-> $stable(frame_o));

  assert_space_timeout_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BITS && line_s && high_len >= W'(SPACE_TIMEOUT)) |=> state == ST_HUNT);

  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    (!line_s && low_len == {W{1'b1}}) |=> low_len == {W{1'b1}});
endmodule

bind ir_pulse_decoder ir_pulse_decoder_chk #(
  .NBITS         (NBITS),
  .W             (W),
  .BCW           (BCW),
  .SPACE_TIMEOUT (SPACE_TIMEOUT)
) i_chk (
  .clk           (clk),
  .rst           (rst),
  .line_s        (line_s),
  .low_len       (low_len),
  .high_len      (high_len),
  .state         (state),
  .bitcnt        (bitcnt),
  .frame_o       (frame_o),
  .frame_valid_o (frame_valid_o)
);

// File: tb/test_ir_pulse_decoder.sv
module test_ir_pulse_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int NB   = 12;
  localparam int S_LO = 36;
  localparam int S_HI = 60;
  localparam int Z_LO = 8;
  localparam int Z_HI = 18;
  localparam int O_HI = 32;
  localparam int TMO  = 40;
  localparam int T_START = 48;
  localparam int T_ZERO  = 12;
  localparam int T_ONE   = 24;
  localparam int T_SPACE = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          line = 1'b1;
  logic [NB-1:0] frame_o;
  logic          frame_valid_o;

  int checks = 0;
  int fails = 0;
  int vcount = 0;
  int vc_mark = 0;
  int strobe_err = 0;
  int change_err = 0;
  logic [NB-1:0] last_word = '0;
  logic [NB-1:0] prev_frame = '0;
  logic          prev_valid = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ir_pulse_decoder #(
    .NBITS(NB), .START_MIN(S_LO), .START_MAX(S_HI), .ZERO_MIN(Z_LO),
    .ZERO_MAX(Z_HI), .ONE_MAX(O_HI), .SPACE_TIMEOUT(TMO)
  ) i_ir_pulse_decoder (
    .clk(clk), .rst(rst), .ir_line_n(line),
    .frame_o(frame_o), .frame_valid_o(frame_valid_o)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (frame_valid_o) begin
        vcount++;
        last_word = frame_o;
        if (prev_valid) strobe_err++;
      end else if (frame_o !== prev_frame) begin
        change_err++;
      end
    end
    prev_frame = frame_o;
    prev_valid = frame_valid_o;
  end

  task automatic mark(input int len, input int sp);
    line = 1'b0;
    repeat (len) @(negedge clk);
    line = 1'b1;
    repeat (sp) @(negedge clk);
  endtask

  function automatic int bit_len(input logic b);
    return b ? T_ONE : T_ZERO;
  endfunction

  // odd_pos/odd_len replace one data mark; gap_pos/gap_len replace the space after one bit.
  task automatic send_frame(input int start_len, input logic [NB-1:0] w,
                            input int odd_pos, input int odd_len,
                            input int gap_pos, input int gap_len);
    vc_mark = vcount;
    mark(start_len, T_SPACE);
    for (int i = 0; i < NB; i++) begin
      mark((i == odd_pos) ? odd_len : bit_len(w[i]),
           (i == gap_pos) ? gap_len : T_SPACE);
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic expect_result(input logic exp_v, input logic [NB-1:0] exp_w,
                               input string req);
    logic ok;
    checks++;
    if (exp_v) ok = (vcount == vc_mark + 1) && (last_word == exp_w) && (frame_o == exp_w);
    else       ok = (vcount == vc_mark) && (frame_o == last_word);
    if (!ok) begin
      fails++;
      $display("FAIL %s: strobes=%0d frame=%h, expected strobes=%0d frame=%h",
               req, vcount - vc_mark, frame_o, exp_v ? 1 : 0, exp_v ? exp_w : last_word);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [NB-1:0] base;
    logic [NB-1:0] w;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    checks++;
    if (frame_o !== '0 || frame_valid_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: frame=%h valid=%b, expected 000 0", frame_o, frame_valid_o);
    end

    // R3 R4 R5: nominal frames with distinct patterns
    send_frame(T_START, 12'hB18, -1, 0, -1, 0); expect_result(1'b1, 12'hB18, "R4 pattern B18");
    send_frame(T_START, 12'h000, -1, 0, -1, 0); expect_result(1'b1, 12'h000, "R3 all zero");
    send_frame(T_START, 12'hFFF, -1, 0, -1, 0); expect_result(1'b1, 12'hFFF, "R3 all one");
    send_frame(T_START, 12'h001, -1, 0, -1, 0); expect_result(1'b1, 12'h001, "R4 first bit lsb");
    send_frame(T_START, 12'h800, -1, 0, -1, 0); expect_result(1'b1, 12'h800, "R4 last bit msb");
    send_frame(T_START, 12'hA5C, -1, 0, -1, 0); expect_result(1'b1, 12'hA5C, "R5 pattern A5C");

    // R2: start length sweep
    for (int L = 30; L <= 66; L++) begin
      w = 12'(12'h3C5 ^ L);
      send_frame(L, w, -1, 0, -1, 0);
      expect_result((L >= S_LO && L <= S_HI), w, "R2 start window");
    end

    // R3 R7: data mark length sweep at bit 5
    base = 12'h5A4;
    for (int D = 4; D <= 36; D++) begin
      w = base;
      w[5] = (D > Z_HI);
      send_frame(T_START, base, 5, D, -1, 0);
      expect_result((D >= Z_LO && D <= O_HI), w, "R3 R7 data mark window");
    end

    // R8: space timeout sweep after bit 6
    for (int S = 36; S <= 46; S++) begin
      w = 12'(12'h6D1 + S);
      send_frame(T_START, w, -1, 0, 6, S);
      expect_result((S <= TMO), w, "R8 space timeout");
    end

    // R7: start inside a frame restarts it
    vc_mark = vcount;
    mark(T_START, T_SPACE);
    for (int i = 0; i < 5; i++) mark(T_ONE, T_SPACE);
    w = 12'h2E7;
    mark(T_START, T_SPACE);
    for (int i = 0; i < NB; i++) mark(bit_len(w[i]), T_SPACE);
    repeat (8) @(negedge clk);
    expect_result(1'b1, w, "R7 restart mid frame");

    // R7: bits without a start are ignored
    vc_mark = vcount;
    for (int i = 0; i < NB; i++) mark(T_ONE, T_SPACE);
    repeat (8) @(negedge clk);
    expect_result(1'b0, '0, "R7 bits without start");

    // R9: 112-cycle mark would wrap a 6-bit counter to 48 (a valid start)
    vc_mark = vcount;
    mark(112, T_SPACE);
    for (int i = 0; i < NB; i++) mark(T_ZERO, T_SPACE);
    repeat (8) @(negedge clk);
    expect_result(1'b0, '0, "R9 saturating mark counter");

    // R5 R6: strobe width and output hold over the whole run
    checks++;
    if (strobe_err != 0) begin
      fails++;
      $display("FAIL R5: strobe longer than one cycle %0d times, expected 0", strobe_err);
    end
    checks++;
    if (change_err != 0) begin
      fails++;
      $display("FAIL R6: frame changed without strobe %0d times, expected 0", change_err);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule